// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block brings a device out of reset with its identity and interface settings. It reads a small three-wire serial EEPROM, with chip select, shift clock, data out and data in. If the first byte carries the expected signature, the block copies a 48-bit station address and two interrupt polling intervals into output registers. While it is loading, the host side is held off. Once loading is over, the block serves single read, write, erase and write-enable commands from a host port. A write or erase is followed by a ready poll on the data-in line, and that poll has a time limit.

Two straps are captured only while reset is held. One picks the address width of the EEPROM (7 or 9 bits). The other skips the load completely. The serial clock comes from the system clock through a half-period counter, so a command frame takes four system cycles per bit with the default settings.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: `strap_size` and `strap_skip` are captured only while `rst` is high. A captured size of 0 gives 7 address bits and a size of 1 gives 9 address bits. A strap change after reset has no effect until the next reset.
- R2: A frame is a start bit of 1, a 2-bit device opcode, the address and then the data, each sent most significant bit first. The opcodes are read 10, write 01, erase 11, and write-enable 00 with the two top address bits set to 11. `ee_do` changes only as `ee_sk` falls, and `ee_di` is sampled as `ee_sk` rises. `ee_sk` stays low while `ee_cs` is low.
- R3: With skip at 0, the block reads bytes 0 to 8 after reset. If byte 0 is 0xA5, `mac_addr[7:0]` takes byte 1, and so on up to `mac_addr[47:40]`, which takes byte 6. `fs_interval` takes byte 7, `hs_interval` takes byte 8, and `cfg_valid` rises.
- R4: If byte 0 is not 0xA5, loading stops after that byte. `cfg_valid` stays 0, `mac_addr` stays 0, `fs_interval` stays 0x01 and `hs_interval` stays 0x04.
- R5: If skip is captured as 1, the EEPROM is not touched after reset, the outputs keep their defaults, and host commands still work.
- R6: `load_busy` is high from reset until loading ends. While it is high, `host_ready` is low, no request is accepted and no `host_ack` appears.
- R7: A request is taken when `host_req` and `host_ready` are both high. The `host_op` codes are 00 read, 01 write, 10 erase and 11 write-enable. Each command ends with a one-cycle `host_ack`, and for a read `host_rdata` is valid in that same cycle.
- R8: After a write or erase frame, `ee_cs` goes low, then high again, and `ee_di` is polled until it reads 1. `host_ack` comes only after the EEPROM reports ready.
- R9: If `ee_di` stays low for `POLL_MAX` poll cycles, the command ends with `err_timeout` set. The next accepted write or erase clears it.
- R10: During reset, `ee_cs`, `ee_sk`, `ee_do`, `host_ack` and `cfg_valid` are 0 and `load_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_size | input | 1 | EEPROM size strap: 0 for 7 address bits, 1 for 9 |
| strap_skip | input | 1 | 1 skips the autoload |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_do | output | 1 | Serial data to the EEPROM |
| ee_di | input | 1 | Serial data and ready from the EEPROM |
| host_req | input | 1 | Host command request |
| host_op | input | 2 | Host opcode |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_ready | output | 1 | Block can accept a command |
| host_ack | output | 1 | One-cycle command completion |
| host_rdata | output | 8 | Read data, valid with host_ack |
| load_busy | output | 1 | Autoload in progress |
| cfg_valid | output | 1 | Signature matched and the load completed |
| mac_addr | output | 48 | Loaded station address |
| fs_interval | output | 8 | Full-speed interrupt polling interval |
| hs_interval | output | 8 | Hi-speed interrupt polling interval |
| err_timeout | output | 1 | Ready poll timed out |

## Verification
A read's data shows up on `host_rdata` together with `host_ack` one cycle after the last falling edge of `ee_sk`. A write or erase acknowledges one cycle after the poll first sees `ee_di` high, or `POLL_MAX` poll cycles after the poll began if it never does. The loaded registers are final once `load_busy` falls. The bench never counts cycles to find these results. A monitor reacts to `host_ack` and pops the expected item that the driver queued, and the register checks run only after `load_busy` has fallen. Every sample is taken on the falling system clock, and the EEPROM model drives `ee_di` with nonblocking updates, so both sides of each clock edge are unambiguous.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam int VEC_W = 32;
  localparam int LEN_W = 6;
  localparam logic [7:0] SIGNATURE = 8'hA5;

  typedef enum logic [1:0] {
    HOP_READ  = 2'b00,
    HOP_WRITE = 2'b01,
    HOP_ERASE = 2'b10,
    HOP_WREN  = 2'b11
  } host_op_e;

  localparam logic [1:0] DEV_READ  = 2'b10;
  localparam logic [1:0] DEV_WRITE = 2'b01;
  localparam logic [1:0] DEV_ERASE = 2'b11;
  localparam logic [1:0] DEV_WREN  = 2'b00;

  typedef enum logic [2:0] {
    ST_BOOT, ST_LD_GO, ST_LD_WAIT, ST_IDLE, ST_H_GO, ST_H_WAIT, ST_GAP, ST_POLL
  } seq_state_e;
endpackage

// File: rtl/ee_strap_hold.sv
module ee_strap_hold (
  input  logic clk,
  input  logic rst,
  input  logic strap_size,
  input  logic strap_skip,
  output logic size_q,
  output logic skip_q
);
  // Straps are sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= strap_size;
      skip_q <= strap_skip;
    end
  end
endmodule

// File: rtl/ee_bit_engine.sv
module ee_bit_engine #(
  parameter int SK_HALF = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [eecfg_pkg::LEN_W-1:0]  len,
  input  logic [eecfg_pkg::VEC_W-1:0]  tx_vec,
  input  logic                         ee_di,
  output logic                         ee_sk,
  output logic                         ee_do,
  output logic                         busy,
  output logic                         done,
  output logic [7:0]                   rx_byte
);
  import eecfg_pkg::*;
  localparam int PH_W = $clog2(SK_HALF + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SK_HALF - 1);

  logic [PH_W-1:0]  ph;
  logic [LEN_W-1:0] left;
  logic [VEC_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ee_sk   <= 1'b0;
      ee_do   <= 1'b0;
      ph      <= '0;
      left    <= '0;
      sh      <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          ee_do <= tx_vec[VEC_W-1];
          sh    <= tx_vec << 1;
          left  <= len;
          ph    <= '0;
          ee_sk <= 1'b0;
        end
      end else if (ph == PH_LAST) begin
        ph <= '0;
        if (!ee_sk) begin
          ee_sk   <= 1'b1;
          rx_byte <= {rx_byte[6:0], ee_di};
        end else begin
          ee_sk <= 1'b0;
          if (left == LEN_W'(1)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            ee_do <= 1'b0;
          end else begin
            left  <= left - LEN_W'(1);
            ee_do <= sh[VEC_W-1];
            sh    <= sh << 1;
          end
        end
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/ee_seq.sv
module ee_seq #(
  parameter int         AW_SM    = 7,
  parameter int         AW_LG    = 9,
  parameter int         CS_GAP   = 2,
  parameter int         POLL_MAX = 64,
  parameter logic [7:0] FS_DEF   = 8'h01,
  parameter logic [7:0] HS_DEF   = 8'h04
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         size_q,
  input  logic                         skip_q,
  input  logic                         host_req,
  input  logic [1:0]                   host_op,
  input  logic [AW_LG-1:0]             host_addr,
  input  logic [7:0]                   host_wdata,
  input  logic                         eng_done,
  input  logic [7:0]                   eng_rx,
  input  logic                         ee_di,
  output logic                         eng_start,
  output logic [eecfg_pkg::LEN_W-1:0]  eng_len,
  output logic [eecfg_pkg::VEC_W-1:0]  eng_vec,
  output logic                         ee_cs,
  output logic                         host_ready,
  output logic                         host_ack,
  output logic [7:0]                   host_rdata,
  output logic                         load_busy,
  output logic                         cfg_valid,
  output logic [47:0]                  mac_addr,
  output logic [7:0]                   fs_interval,
  output logic [7:0]                   hs_interval,
  output logic                         err_timeout
);
  import eecfg_pkg::*;
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [AW_LG-1:0] WREN_LG = AW_LG'(3) << (AW_LG - 2);
  localparam logic [AW_LG-1:0] WREN_SM = AW_LG'(3) << (AW_SM - 2);

  seq_state_e        state;
  host_op_e          cur_hop;
  logic [1:0]        f_op;
  logic [AW_LG-1:0]  f_addr;
  logic [7:0]        f_data;
  logic              f_dat_en;
  logic [3:0]        ld_idx;
  logic [2:0]        mac_sel;
  logic [GAP_W-1:0]  gap_cnt;
  logic [POLL_W-1:0] poll_cnt;
  logic [LEN_W-1:0]  aw, tail;
  logic [VEC_W-1:0]  val;

  // Build the left-aligned frame from the registered command fields.
  always_comb begin
    aw      = size_q ? LEN_W'(AW_LG) : LEN_W'(AW_SM);
    tail    = f_dat_en ? LEN_W'(8) : LEN_W'(0);
    eng_len = LEN_W'(3) + aw + tail;
    val     = (VEC_W'(1) << (LEN_W'(2) + aw + tail))
            | (VEC_W'(f_op) << (aw + tail))
            | ((VEC_W'(f_addr) & ((VEC_W'(1) << aw) - VEC_W'(1))) << tail)
            | VEC_W'(f_data);
    eng_vec = val << (LEN_W'(VEC_W) - eng_len);
  end

  assign eng_start  = (state == ST_LD_GO) || (state == ST_H_GO);
  assign load_busy  = (state == ST_BOOT) || (state == ST_LD_GO) || (state == ST_LD_WAIT);
  assign host_ready = (state == ST_IDLE);
  assign mac_sel    = ld_idx[2:0] - 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_BOOT;
      cur_hop     <= HOP_READ;
      f_op        <= DEV_READ;
      f_addr      <= '0;
      f_data      <= '0;
      f_dat_en    <= 1'b1;
      ld_idx      <= '0;
      gap_cnt     <= '0;
      poll_cnt    <= '0;
      ee_cs       <= 1'b0;
      host_ack    <= 1'b0;
      host_rdata  <= '0;
      cfg_valid   <= 1'b0;
      mac_addr    <= '0;
      fs_interval <= FS_DEF;
      hs_interval <= HS_DEF;
      err_timeout <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      unique case (state)
        ST_BOOT: state <= skip_q ? ST_IDLE : ST_LD_GO;
        ST_LD_GO, ST_H_GO: begin
          ee_cs <= 1'b1;
          state <= (state == ST_LD_GO) ? ST_LD_WAIT : ST_H_WAIT;
        end
        ST_LD_WAIT: if (eng_done) begin
          ee_cs <= 1'b0;
          if (ld_idx == 4'd0 && eng_rx != SIGNATURE) begin
            state <= ST_IDLE;
          end else begin
            if (ld_idx >= 4'd1 && ld_idx <= 4'd6) mac_addr[{mac_sel, 3'b000} +: 8] <= eng_rx;
            else if (ld_idx == 4'd7) fs_interval <= eng_rx;
            else if (ld_idx == 4'd8) hs_interval <= eng_rx;
            if (ld_idx == 4'd8) begin
              cfg_valid <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              ld_idx <= ld_idx + 4'd1;
              f_addr <= AW_LG'(ld_idx + 4'd1);
              state  <= ST_LD_GO;
            end
          end
        end
        ST_IDLE: if (host_req) begin
          cur_hop  <= host_op_e'(host_op);
          f_data   <= (host_op == HOP_WRITE) ? host_wdata : 8'h00;
          f_dat_en <= (host_op == HOP_READ) || (host_op == HOP_WRITE);
          unique case (host_op_e'(host_op))
            HOP_READ:  begin f_op <= DEV_READ;  f_addr <= host_addr; end
            HOP_WRITE: begin f_op <= DEV_WRITE; f_addr <= host_addr; err_timeout <= 1'b0; end
            HOP_ERASE: begin f_op <= DEV_ERASE; f_addr <= host_addr; err_timeout <= 1'b0; end
            HOP_WREN:  begin f_op <= DEV_WREN;  f_addr <= size_q ? WREN_LG : WREN_SM; end
          endcase
          state <= ST_H_GO;
        end
        ST_H_WAIT: if (eng_done) begin
          ee_cs <= 1'b0;
          if (cur_hop == HOP_READ || cur_hop == HOP_WREN) begin
            if (cur_hop == HOP_READ) host_rdata <= eng_rx;
            host_ack <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            gap_cnt <= '0;
            state   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
            ee_cs    <= 1'b1;
            poll_cnt <= '0;
            state    <= ST_POLL;
          end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
          end
        end
        ST_POLL: begin
          if (ee_di || poll_cnt == POLL_W'(POLL_MAX - 1)) begin
            err_timeout <= !ee_di;
            ee_cs       <= 1'b0;
            host_ack    <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            poll_cnt <= poll_cnt + POLL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int         AW_SM    = 7,
  parameter int         AW_LG    = 9,
  parameter int         SK_HALF  = 2,
  parameter int         CS_GAP   = 2,
  parameter int         POLL_MAX = 64,
  parameter logic [7:0] FS_DEF   = 8'h01,
  parameter logic [7:0] HS_DEF   = 8'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_size,
  input  logic             strap_skip,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_do,
  input  logic             ee_di,
  input  logic             host_req,
  input  logic [1:0]       host_op,
  input  logic [AW_LG-1:0] host_addr,
  input  logic [7:0]       host_wdata,
  output logic             host_ready,
  output logic             host_ack,
  output logic [7:0]       host_rdata,
  output logic             load_busy,
  output logic             cfg_valid,
  output logic [47:0]      mac_addr,
  output logic [7:0]       fs_interval,
  output logic [7:0]       hs_interval,
  output logic             err_timeout
);
  import eecfg_pkg::*;

  logic             size_q, skip_q;
  logic             eng_start, eng_busy, eng_done;
  logic [LEN_W-1:0] eng_len;
  logic [VEC_W-1:0] eng_vec;
  logic [7:0]       eng_rx;

  ee_strap_hold u_straps (
    .clk(clk), .rst(rst), .strap_size(strap_size), .strap_skip(strap_skip),
    .size_q(size_q), .skip_q(skip_q)
  );

  ee_bit_engine #(.SK_HALF(SK_HALF)) u_engine (
    .clk(clk), .rst(rst), .start(eng_start), .len(eng_len), .tx_vec(eng_vec),
    .ee_di(ee_di), .ee_sk(ee_sk), .ee_do(ee_do), .busy(eng_busy),
    .done(eng_done), .rx_byte(eng_rx)
  );

  ee_seq #(
    .AW_SM(AW_SM), .AW_LG(AW_LG), .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX),
    .FS_DEF(FS_DEF), .HS_DEF(HS_DEF)
  ) u_seq (
    .clk(clk), .rst(rst), .size_q(size_q), .skip_q(skip_q),
    .host_req(host_req), .host_op(host_op), .host_addr(host_addr),
    .host_wdata(host_wdata), .eng_done(eng_done), .eng_rx(eng_rx), .ee_di(ee_di),
    .eng_start(eng_start), .eng_len(eng_len), .eng_vec(eng_vec), .ee_cs(ee_cs),
    .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
    .load_busy(load_busy), .cfg_valid(cfg_valid), .mac_addr(mac_addr),
    .fs_interval(fs_interval), .hs_interval(hs_interval), .err_timeout(err_timeout)
  );
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk (
  input logic clk,
  input logic rst,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do,
  input logic host_req,
  input logic host_ready,
  input logic host_ack,
  input logic load_busy,
  input logic cfg_valid
);
  assert_sk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);

  assert_do_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_do));

  assert_valid_after_load_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> $past(load_busy));

  assert_no_ack_loading_R6: assert property (@(posedge clk) disable iff (rst)
    load_busy |-> !host_ack);

  assert_accept_drops_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_ready) |=> !host_ready);

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk u_chk (
  .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
  .host_req(host_req), .host_ready(host_ready), .host_ack(host_ack),
  .load_busy(load_busy), .cfg_valid(cfg_valid)
);

// File: tb/eeprom_cfg_loader_tb_top.sv
module eeprom_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_MAX   = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_size = 1'b1, strap_skip = 1'b0;
  logic        ee_cs, ee_sk, ee_do;
  logic        m_di = 1'b0;
  logic        host_req = 1'b0;
  logic [1:0]  host_op = 2'b00;
  logic [8:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready, host_ack, load_busy, cfg_valid, err_timeout;
  logic [7:0]  host_rdata, fs_interval, hs_interval;
  logic [47:0] mac_addr;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_cfg_loader #(.POLL_MAX(POLL_MAX)) dut_i (
    .clk(clk), .rst(rst), .strap_size(strap_size), .strap_skip(strap_skip),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(m_di),
    .host_req(host_req), .host_op(host_op), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_ack(host_ack),
    .host_rdata(host_rdata), .load_busy(load_busy), .cfg_valid(cfg_valid),
    .mac_addr(mac_addr), .fs_interval(fs_interval), .hs_interval(hs_interval),
    .err_timeout(err_timeout)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- serial EEPROM model ----------------
  logic [7:0] mem [512];
  int   m_aw = 9, busy_len = 20, busy_cnt = 0, m_n = 0;
  bit   m_on = 0, m_we = 0, cs_prev = 0, sk_prev = 0, rd_on, rd_bit = 0;
  logic [1:0] m_op = 0;
  logic [8:0] m_ad = 0;
  logic [7:0] m_dat = 0;
  int   cs_rises = 0, sk_viol = 0;

  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
    if (!rst && ee_cs && !cs_prev) cs_rises++;
    if (!ee_cs && ee_sk) sk_viol++;
    if (cs_prev && !ee_cs) begin
      if (m_on && m_we && m_op == 2'b01 && m_n == 2 + m_aw + 8) begin
        mem[m_ad] = m_dat; busy_cnt = busy_len;
      end else if (m_on && m_we && m_op == 2'b11 && m_n == 2 + m_aw) begin
        mem[m_ad] = 8'hFF; busy_cnt = busy_len;
      end
      m_on = 0; m_n = 0;
    end
    if (ee_cs && !sk_prev && ee_sk) begin
      if (!m_on) begin
        if (ee_do) begin m_on = 1; m_n = 0; m_op = 0; m_ad = 0; m_dat = 0; end
      end else begin
        if (m_n < 2) m_op = {m_op[0], ee_do};
        else if (m_n < 2 + m_aw) m_ad = {m_ad[7:0], ee_do};
        else m_dat = {m_dat[6:0], ee_do};
        m_n++;
        if (m_n == 2 + m_aw && m_op == 2'b00) m_we = ((m_ad >> (m_aw - 2)) == 9'd3);
      end
    end
    rd_on = m_on && m_op == 2'b10 && m_n >= 2 + m_aw && m_n < 2 + m_aw + 8;
    if (ee_cs && sk_prev && !ee_sk && rd_on) rd_bit = mem[m_ad][7 - (m_n - 2 - m_aw)];
    m_di <= rd_on ? rd_bit : (busy_cnt == 0);
    cs_prev = ee_cs; sk_prev = ee_sk;
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit is_rd; bit is_wr; logic [7:0] rd; bit err; string tag; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (!rst && host_ack) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected ack", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_rd) check(host_rdata == e.rd, e.tag, host_rdata, e.rd);
        check(err_timeout == e.err, {e.tag, " err (R9)"}, err_timeout, e.err);
        if (e.is_wr && !e.err) check(busy_cnt == 0, {e.tag, " ack after ready (R8)"}, busy_cnt, 0);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [8:0] a, input logic [7:0] d,
                     input logic [7:0] exp_rd, input bit exp_err, input string tag);
    exp_t e;
    e.is_rd = (op == 2'b00); e.is_wr = (op == 2'b01 || op == 2'b10);
    e.rd = exp_rd; e.err = exp_err; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1; host_op = op; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0;
    while (!host_ack) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic sz, input logic sk);
    strap_size = sz; strap_skip = sk; m_aw = sz ? 9 : 7;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    cs_rises = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    mem[0] = 8'hA5; mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33;
    mem[4] = 8'h44; mem[5] = 8'h55; mem[6] = 8'h66; mem[7] = 8'h0A; mem[8] = 8'h02;
    mem[300] = 8'h5A;

    // Reset state (R10)
    strap_size = 1; strap_skip = 0; rst = 1;
    repeat (3) @(negedge clk);
    check(!ee_cs && !ee_sk && !ee_do, "R10 serial pins low in reset", {ee_cs, ee_sk, ee_do}, 0);
    check(!host_ack && !cfg_valid, "R10 ack/valid low in reset", {host_ack, cfg_valid}, 0);
    check(load_busy == 1, "R10 load_busy in reset", load_busy, 1);
    rst = 0;
    @(negedge clk);
    check(load_busy && !host_ready, "R6 held off after reset", {load_busy, host_ready}, 2'b10);
    // R6: a request during loading is not taken
    host_req = 1; host_op = 2'b00; host_addr = 9'd3;
    repeat (40) begin
      @(negedge clk);
      if (host_ack || host_ready) check(0, "R6 request seen while loading", {host_ack, host_ready}, 0);
    end
    host_req = 0;
    while (load_busy) @(negedge clk);
    check(mac_addr == 48'h665544332211, "R3 mac_addr", mac_addr, 48'h665544332211);
    check(fs_interval == 8'h0A, "R3 fs_interval", fs_interval, 8'h0A);
    check(hs_interval == 8'h02, "R3 hs_interval", hs_interval, 8'h02);
    check(cfg_valid == 1, "R3 cfg_valid", cfg_valid, 1);

    // Host commands, 9-bit addressing (R1, R2, R7, R8)
    cmd(2'b01, 9'd300, 8'h3C, 0, 0, "R7 write without enable");
    cmd(2'b00, 9'd300, 0, 8'h5A, 0, "R2 read unchanged without enable");
    cmd(2'b11, 0, 0, 0, 0, "R2 write enable");
    cmd(2'b01, 9'd300, 8'h3C, 0, 0, "R8 write");
    cmd(2'b00, 9'd300, 0, 8'h3C, 0, "R7 read back write");
    cmd(2'b10, 9'd300, 0, 0, 0, "R8 erase");
    cmd(2'b00, 9'd300, 0, 8'hFF, 0, "R8 read after erase");
    cmd(2'b00, 9'd511, 0, mem[511], 0, "R1 read top 9-bit address");

    // Strap change without reset is ignored (R1)
    strap_size = 0;
    cmd(2'b00, 9'd300, 0, 8'hFF, 0, "R1 strap change ignored");

    // Ready poll timeout and clear (R9)
    busy_len = 200;
    cmd(2'b01, 9'd10, 8'h77, 0, 1, "R9 poll timeout");
    busy_len = 20;
    cmd(2'b01, 9'd11, 8'h88, 0, 0, "R9 error cleared");
    cmd(2'b00, 9'd10, 0, 8'h77, 0, "R9 data of timed-out write");

    // Bad signature with 7-bit part (R4, R1)
    mem[0] = 8'h00;
    do_reset(0, 0);
    while (load_busy) @(negedge clk);
    check(cfg_valid == 0, "R4 cfg_valid low", cfg_valid, 0);
    check(mac_addr == 48'h0, "R4 mac default", mac_addr, 0);
    check(fs_interval == 8'h01 && hs_interval == 8'h04, "R4 interval defaults",
          {fs_interval, hs_interval}, 16'h0104);
    check(cs_rises == 1, "R4 only signature read", cs_rises, 1);
    cmd(2'b00, 9'd5, 0, 8'h55, 0, "R1 read with 7-bit address");

    // Skip strap (R5)
    mem[0] = 8'hA5;
    do_reset(1, 1);
    repeat (20) @(negedge clk);
    check(load_busy == 0, "R5 load ends", load_busy, 0);
    check(cs_rises == 0, "R5 no EEPROM access", cs_rises, 0);
    check(cfg_valid == 0 && mac_addr == 0, "R5 defaults kept", {cfg_valid, mac_addr}, 0);
    cmd(2'b00, 9'd7, 0, 8'h0A, 0, "R5 host read while skipped");

    check(sk_viol == 0, "R2 sk low while cs low", sk_viol, 0);
    check(exp_q.size() == 0, "R7 all commands acknowledged", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule